// File: doc/BRIEF.md
# Serial Peripheral Master with Bit-Granular Transfers

This block is a clocked serial master that a processor drives through four 16-bit registers. Software first sets the transfer shape: how many bits go out (1 to 8), how many come back in the shared-line mode, the clock polarity, the serial clock rate and the guard time around each transfer. A write to the data register then launches one transfer. A status register reports whether the engine is running and holds three completion flags. Software clears each flag by writing a one to it.

Two wiring modes are supported. In the four-wire mode, every clock period both shifts one bit out on the data output and captures one bit from the data input. In the three-wire mode the outgoing and incoming data share one line. The block first sends its transmit bits with the output driver enabled, then releases the line and captures the programmed number of receive bits. The select line either follows the transfer automatically or is held at a level that software writes.

Register map (2-bit word address): 0 = configuration, 1 = timing, 2 = data, 3 = status. Configuration bits: [2:0] transmit length code, [5:3] receive length code, [6] shared-line mode, [7] automatic select, [8] manual select asserted, [9] clock idle level. Timing: [7:0] half-period divider `H`, [15:8] guard length `G`. Status: [0] busy, [1] transmit-done, [2] transfer-done, [3] receive-ready.

Top module: `spi_part`

## Requirements
- R1: After reset, `ssN` is high, `sclk` is low, `sdOe` is high and the status register reads zero.
- R2: A transmit length code of 0 means 8 bits and codes 1 to 7 mean that many bits. The lowest n bits of the written data byte go out on `sdOut` starting with bit n-1. One bit is sent per serial clock period, and each bit is captured by the bench on the edge that leaves the idle level.
- R3: In four-wire mode, each bit period also samples `sdIn` on the edge that leaves the idle level. The data register then reads the n captured bits right-aligned, with the first captured bit highest and the upper bits zero.
- R4: In shared-line mode, the transmit bits are followed by m receive bits, where receive code 0 means 8 bits and codes 1 to 7 mean that many bits. `sdOe` is high only during transmit bits and low during receive bits and while idle. The data register reads the m received bits right-aligned.
- R5: While idle, `sclk` rests at configuration bit 9. Each half of a serial clock period lasts H+1 system clock cycles.
- R6: Status bit 0 is high from the cycle after the starting data write until the transfer ends.
- R7: With automatic select, `ssN` is low exactly while the block is busy. The first clock edge comes G+H+1 cycles after `ssN` falls, and `ssN` rises G cycles after `sclk` returns to idle after the last bit.
- R8: With automatic select off, `ssN` is the inverse of configuration bit 8 and does not change during transfers.
- R9: Status bit 1 sets when the last transmit bit ends. Bits 2 and 3 set when the transfer ends. Writing ones to status bits 1 to 3 clears those bits.
- R10: A data-register write while busy is ignored: the running transfer is unchanged and no new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational from address) |
| sclk | output | 1 | Serial clock |
| sdOut | output | 1 | Serial data out |
| sdOe | output | 1 | Output enable for the data line |
| sdIn | input | 1 | Serial data in (the shared line in three-wire mode) |
| ssN | output | 1 | Active-low slave select |

## Verification
The assertions assume that software does not rewrite the configuration or timing registers while a transfer is running. They also assume that the start strobe arrives only through a register write. The random stimulus respects both assumptions: it reprograms those registers only while the status reads idle. Its only write during a transfer goes to the data register, which tests that such a write is ignored. The input data line is changed only just after a capturing edge, so it is stable on every sampling edge.

// File: rtl/spi_part_pkg.sv
package spi_part_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = $clog2(BYTE_W);
  localparam int REG_W  = 16;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TIME = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} xfer_state_e;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic txEnd;
    logic finish;
  } xfer_strobe_t;

  typedef struct packed {
    logic             cpol;
    logic             ssAssert;
    logic             autoSs;
    logic             threeWire;
    logic [LEN_W-1:0] rxLen;
    logic [LEN_W-1:0] txLen;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_part_dp.sv
module spi_part_dp
  import spi_part_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  xfer_strobe_t      strb,
  input  logic              busy,
  input  logic              sdIn,
  output xfer_cfg_t         cfg,
  output logic [DIV_W-1:0]  halfDiv,
  output logic [GAP_W-1:0]  gapLen,
  output logic              dataWr,
  output logic              sdOut
);
  localparam int CFG_W = $bits(xfer_cfg_t);

  logic [BYTE_W-1:0] txShift, rxShift, rxData;
  logic              txDone, xferDone, rxReady;
  logic [LEN_W:0]    loadBits;
  logic [BYTE_W-1:0] loadVal;
  logic [2:0]        clrMask;

  assign dataWr   = regWr && (regAddr == ADDR_DATA);
  assign loadBits = (cfg.txLen == '0) ? (LEN_W+1)'(BYTE_W) : {1'b0, cfg.txLen};
  assign loadVal  = regWrData[BYTE_W-1:0] << (BYTE_W - int'(loadBits));
  assign clrMask  = (regWr && regAddr == ADDR_STAT) ? regWrData[3:1] : 3'b000;
  assign sdOut    = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      halfDiv <= '0;
      gapLen  <= '0;
    end else if (regWr && regAddr == ADDR_CTRL) begin
      cfg <= xfer_cfg_t'(regWrData[CFG_W-1:0]);
    end else if (regWr && regAddr == ADDR_TIME) begin
      halfDiv <= regWrData[DIV_W-1:0];
      gapLen  <= regWrData[DIV_W+GAP_W-1:DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (strb.load) begin
        txShift <= loadVal;
        rxShift <= '0;
      end else begin
        if (strb.shift)  txShift <= {txShift[BYTE_W-2:0], 1'b0};
        if (strb.sample) rxShift <= {rxShift[BYTE_W-2:0], sdIn};
      end
      if (strb.finish) rxData <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDone   <= 1'b0;
      xferDone <= 1'b0;
      rxReady  <= 1'b0;
    end else begin
      txDone   <= strb.txEnd  | (txDone   & ~clrMask[0]);
      xferDone <= strb.finish | (xferDone & ~clrMask[1]);
      rxReady  <= strb.finish | (rxReady  & ~clrMask[2]);
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTRL: regRdData[CFG_W-1:0] = cfg;
      ADDR_TIME: regRdData[DIV_W+GAP_W-1:0] = {gapLen, halfDiv};
      ADDR_DATA: regRdData[BYTE_W-1:0] = rxData;
      default:   regRdData[3:0] = {rxReady, xferDone, txDone, busy};
    endcase
  end
endmodule

// File: rtl/spi_part_ctl.sv
module spi_part_ctl
  import spi_part_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  xfer_cfg_t        cfg,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [GAP_W-1:0] gapLen,
  input  logic             dataWr,
  output xfer_strobe_t     strb,
  output logic             busy,
  output logic             sclk,
  output logic             sdOe
);
  xfer_state_e      st;
  logic [DIV_W-1:0] divCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [LEN_W:0]   bitCnt, txBits, rxBits, curBits;
  logic             phase, rxPh;
  logic             halfEnd, lastBit, gapDone, lastPhase;

  assign txBits    = (cfg.txLen == '0) ? (LEN_W+1)'(BYTE_W) : {1'b0, cfg.txLen};
  assign rxBits    = (cfg.rxLen == '0) ? (LEN_W+1)'(BYTE_W) : {1'b0, cfg.rxLen};
  assign curBits   = rxPh ? rxBits : txBits;
  assign halfEnd   = (divCnt == halfDiv);
  assign lastBit   = (bitCnt == curBits - 1'b1);
  assign gapDone   = (gapCnt == gapLen - 1'b1);
  assign lastPhase = rxPh || !cfg.threeWire;

  assign busy = (st != ST_IDLE);
  assign sclk = cfg.cpol ^ ((st == ST_SHIFT) && phase);
  assign sdOe = !cfg.threeWire || ((st == ST_SHIFT) && !rxPh);

  always_comb begin
    strb      = '0;
    strb.load = (st == ST_IDLE) && dataWr;
    if (st == ST_SHIFT && halfEnd) begin
      if (!phase) begin
        strb.sample = !cfg.threeWire || rxPh;
      end else begin
        if (!rxPh) begin
          strb.txEnd = lastBit;
          strb.shift = !lastBit;
        end
        strb.finish = lastBit && lastPhase && (gapLen == '0);
      end
    end
    if (st == ST_TRAIL && gapDone) strb.finish = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      divCnt <= '0;
      gapCnt <= '0;
      bitCnt <= '0;
      phase  <= 1'b0;
      rxPh   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (dataWr) begin
          divCnt <= '0;
          gapCnt <= '0;
          bitCnt <= '0;
          phase  <= 1'b0;
          rxPh   <= 1'b0;
          st     <= (gapLen == '0) ? ST_SHIFT : ST_LEAD;
        end
        ST_LEAD: begin
          if (gapDone) begin
            gapCnt <= '0;
            st     <= ST_SHIFT;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!halfEnd) begin
            divCnt <= divCnt + 1'b1;
          end else begin
            divCnt <= '0;
            phase  <= ~phase;
            if (phase) begin
              if (!lastBit) begin
                bitCnt <= bitCnt + 1'b1;
              end else if (!lastPhase) begin
                rxPh   <= 1'b1;
                bitCnt <= '0;
              end else begin
                gapCnt <= '0;
                st     <= (gapLen == '0) ? ST_IDLE : ST_TRAIL;
              end
            end
          end
        end
        default: begin
          if (gapDone) st <= ST_IDLE;
          else         gapCnt <= gapCnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_part.sv
module spi_part
  import spi_part_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             sclk,
  output logic             sdOut,
  output logic             sdOe,
  input  logic             sdIn,
  output logic             ssN
);
  xfer_cfg_t        cfg;
  xfer_strobe_t     strb;
  logic [DIV_W-1:0] halfDiv;
  logic [GAP_W-1:0] gapLen;
  logic             dataWr, busy;

  spi_part_dp #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb), .busy(busy),
    .sdIn(sdIn), .cfg(cfg), .halfDiv(halfDiv), .gapLen(gapLen),
    .dataWr(dataWr), .sdOut(sdOut)
  );

  spi_part_ctl #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .halfDiv(halfDiv), .gapLen(gapLen),
    .dataWr(dataWr), .strb(strb), .busy(busy), .sclk(sclk), .sdOe(sdOe)
  );

  assign ssN = cfg.autoSs ? !busy : !cfg.ssAssert;
endmodule

// File: rtl/spi_part_chk.sv
module spi_part_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic dataWr,
  input logic sdOe,
  input logic sclk,
  input logic threeWire,
  input logic cpol,
  input logic finish
);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(dataWr));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataWr) |=> busy);

  // R4
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (threeWire && !busy) |-> !sdOe);

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == cpol));

  // R9
  finish_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> !busy);
endmodule

bind spi_part spi_part_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .dataWr(dataWr), .sdOe(sdOe),
  .sclk(sclk), .threeWire(cfg.threeWire), .cpol(cfg.cpol), .finish(strb.finish)
);

// File: tb/spi_part_test.sv
module spi_part_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd3;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        sclk, sdOut, sdOe, ssN;
  logic        sdIn = 1'b0;
  int          nChecks = 0;
  int          nFails = 0;

  always #10 clk = ~clk;

  spi_part uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk),
    .sdOut(sdOut), .sdOe(sdOe), .sdIn(sdIn), .ssN(ssN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = 2'd3;
    #1;
  endtask

  function automatic int bitsOf(input logic [2:0] code);
    return (code == 3'd0) ? 8 : int'(code);
  endfunction

  function automatic int lowMask(input int n);
    return (1 << n) - 1;
  endfunction

  task automatic runXfer(input logic [7:0] data, input logic [2:0] txc,
                         input logic [2:0] rxc, input bit three, input bit cp,
                         input int div, input int gap, input bit auto,
                         input bit ssa, input logic [7:0] pat, input bit midWrite);
    int n, m, idx, txEdges, rxEdges, txCap, firstAct, hiLen, lastIdle, ssHigh, oeBad, ssBad;
    bit prev, inFirst, wrPend, sawRxCheck;
    n = bitsOf(txc); m = three ? bitsOf(rxc) : n;
    writeReg(2'd0, {6'd0, cp, ssa, auto, three, rxc, txc});
    writeReg(2'd1, {gap[7:0], div[7:0]});
    writeReg(2'd3, 16'h000E);
    // R5 idle level
    check(sclk == cp, "R5 idle sclk", sclk, cp);
    sdIn = pat[7];
    txEdges = 0; rxEdges = 0; txCap = 0; firstAct = 0; hiLen = 0;
    lastIdle = 0; ssHigh = 0; oeBad = 0; ssBad = 0;
    prev = cp; inFirst = 0; wrPend = 0; sawRxCheck = 0;
    writeReg(2'd2, {8'd0, data});
    idx = 1;
    // R6 busy visible right after the start write
    check(regRdData[0] == 1'b1, "R6 busy after start", regRdData[0], 1);
    if (auto) check(ssN == 1'b0, "R7 select low on start", ssN, 0);
    while (regRdData[0] == 1'b1 && idx < 5000) begin
      if (!auto && ssN != !ssa) ssBad++;
      if (sclk != cp && prev == cp) begin
        if (firstAct == 0) begin firstAct = idx; inFirst = 1; end
        if (three && !sdOe) begin
          if (!sawRxCheck) begin
            sawRxCheck = 1;
            // R9 transmit flag already set, transfer flag not yet
            check(regRdData[2:1] == 2'b01, "R9 mid flags", regRdData[2:1], 1);
          end
          rxEdges++;
          if (rxEdges < 8) sdIn = pat[7 - rxEdges];
        end else begin
          if (!sdOe) oeBad++;
          txEdges++;
          txCap = (txCap << 1) | int'(sdOut);
          if (!three) begin
            rxEdges++;
            if (rxEdges < 8) sdIn = pat[7 - rxEdges];
          end
        end
      end
      if (sclk == cp && prev != cp) begin lastIdle = idx; inFirst = 0; end
      if (inFirst && sclk != cp) hiLen++;
      prev = sclk;
      if (midWrite && idx == 3) begin
        regWr = 1'b1; regAddr = 2'd2; regWrData = {8'd0, ~data}; wrPend = 1;
      end
      @(negedge clk);
      if (wrPend) begin regWr = 1'b0; regAddr = 2'd3; wrPend = 0; end
      #1;
      idx++;
      if (auto && ssN == 1'b1 && ssHigh == 0) ssHigh = idx;
    end
    if (sclk == cp && prev != cp) lastIdle = idx;
    // R2
    check(txEdges == n, "R2 tx bit count", txEdges, n);
    check(txCap == (int'(data) & lowMask(n)), "R2 tx bits", txCap, int'(data) & lowMask(n));
    // R4 / R3
    check(rxEdges == m, three ? "R4 rx bit count" : "R3 rx bit count", rxEdges, m);
    check(oeBad == 0, "R4 driver enable on tx bits", oeBad, 0);
    // R5
    check(hiLen == div + 1, "R5 half period", hiLen, div + 1);
    // R7
    check(firstAct == gap + div + 2, "R7 lead time", firstAct, gap + div + 2);
    if (auto) begin
      check(ssHigh == idx, "R7 select release with idle", ssHigh, idx);
      check(idx - lastIdle == gap, "R7 trail time", idx - lastIdle, gap);
    end else begin
      check(ssBad == 0, "R8 manual select steady", ssBad, 0);
    end
    // R9
    check(regRdData[3:0] == 4'b1110, "R9 end flags", regRdData[3:0], 4'hE);
    regAddr = 2'd2; #1;
    check(regRdData[7:0] == (pat >> (8 - m)), three ? "R4 rx data" : "R3 rx data",
          regRdData[7:0], pat >> (8 - m));
    regAddr = 2'd3; #1;
    if (midWrite) begin
      repeat (6) @(negedge clk);
      #1;
      // R10 no restart from the ignored write
      check(regRdData[0] == 1'b0, "R10 no second transfer", regRdData[0], 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2417));
    #35 rstN = 1'b1;
    @(negedge clk); #1;
    // R1
    check(ssN == 1'b1, "R1 reset ssN", ssN, 1);
    check(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    check(sdOe == 1'b1, "R1 reset sdOe", sdOe, 1);
    check(regRdData == 16'h0, "R1 reset status", regRdData, 0);

    // directed corners: full byte, single bit, shared line, long gap
    runXfer(8'hA5, 3'd0, 3'd0, 0, 0, 0, 0, 1, 0, 8'h3C, 0);
    runXfer(8'h01, 3'd1, 3'd0, 0, 1, 2, 3, 1, 0, 8'h80, 0);
    runXfer(8'h0B, 3'd4, 3'd3, 1, 0, 1, 2, 1, 0, 8'hC1, 0);
    runXfer(8'h6E, 3'd7, 3'd0, 1, 1, 0, 0, 1, 0, 8'h5A, 0);
    runXfer(8'hF0, 3'd0, 3'd0, 0, 0, 1, 1, 1, 0, 8'h99, 1);

    // R9 write-one-to-clear, one bit then the rest
    writeReg(2'd3, 16'h0002);
    check(regRdData[3:0] == 4'b1100, "R9 clear tx flag", regRdData[3:0], 4'hC);
    writeReg(2'd3, 16'h000C);
    check(regRdData[3:0] == 4'b0000, "R9 clear rest", regRdData[3:0], 0);

    // R8 manual select
    writeReg(2'd0, 16'h0100);
    check(ssN == 1'b0, "R8 manual assert", ssN, 0);
    runXfer(8'h37, 3'd5, 3'd0, 0, 0, 1, 1, 0, 1, 8'hE7, 0);
    writeReg(2'd0, 16'h0000);
    check(ssN == 1'b1, "R8 manual release", ssN, 1);

    for (int k = 0; k < 24; k++) begin
      runXfer(8'($urandom), 3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
              int'($urandom % 4), int'($urandom % 4), 1'b1, 1'b0, 8'($urandom),
              ($urandom % 5) == 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule